// File: doc/BRIEF.md
# Flash Toggle-Bit Status Poller

This block sits on the host side of a parallel NOR flash. It decides when an embedded program or erase operation inside the flash has finished. The command sequence that starts the operation is sent by other logic. Once that sequence is out, a one-cycle `start` pulse hands the status check to this block.

The poller reads one status address over a simple request/acknowledge bus. It compares status bit 6, which toggles on every read while the flash is busy, across pairs of back-to-back reads. It also looks at status bit 5, the timeout flag.

- A pair in which bit 6 holds still means the operation has finished. The block reports success.
- A toggling pair with bit 5 set triggers one confirming pair. The toggling may have stopped at the same moment the flag was raised.
- If the confirming pair still toggles, the block writes the reset command. This returns the flash to array-read mode, and the block then reports failure.
- A toggling pair with bit 5 clear leads to another pair. A programmable pair limit bounds this loop.

While it polls, the block can give the bus away when asked. After a resume pulse it starts the check again from the first read.

Top module: `tbit_poller`

## Requirements
- R1: After reset, and whenever reset is asserted, `busy`, `suspended`, `done`, `fail` and `mem_req` are all low.
- R2: A `start` pulse while idle raises `busy` and issues reads (`mem_we` low) at `status_addr`. If bit 6 of the data word is equal in two consecutive reads, `done` pulses high for exactly one cycle and `busy` is low in that same cycle.
- R3: If bit 6 differs within a pair and bit 5 of the second read is 0, the block starts a new pair of reads, as long as the pair limit has not been reached.
- R4: If bit 6 differs within a pair and bit 5 of the second read is 1, exactly one confirming pair follows. If bit 6 is equal in the confirming pair, `done` pulses.
- R5: If bit 6 still differs in the confirming pair, the block issues one write with `mem_we` high and `mem_wdata` = 16'h00F0. After that write is acknowledged, `fail` pulses for one cycle.
- R6: `max_polls` caps the number of first-step pairs that toggle with bit 5 clear. When the pair numbered `max_polls` toggles with bit 5 clear, the block takes the reset-write-and-fail path of R5. The values 0 and 1 both allow exactly one pair.
- R7: Once `mem_req` is raised, it stays high with `mem_addr`, `mem_we` and `mem_wdata` unchanged until the cycle in which `mem_ack` is high. Each acknowledge completes exactly one transfer.
- R8: If `yield_req` is high when the next first-step read would be issued, no read is issued. `suspended` goes high, `busy` stays high and `mem_req` stays low. Reads of a confirming pair and the reset write are not abandoned.
- R9: A `resume` pulse while suspended clears `suspended`, clears the pair count and restarts at the first read of a new pair. A `start` pulse while `busy` is high is ignored.
- R10: `done` and `fail` are never high together, and neither is high in two consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | One-cycle pulse that begins status polling |
| yield_req | input | 1 | Level that asks the block to release the bus at the next first-step read |
| resume | input | 1 | One-cycle pulse that restarts polling after a yield |
| status_addr | input | ADDR_W | Address that is polled and that receives the reset write |
| max_polls | input | CNT_W | Limit on first-step toggling pairs |
| mem_req | output | 1 | Bus request, held until acknowledged |
| mem_we | output | 1 | 1 for write, 0 for read |
| mem_addr | output | ADDR_W | Bus address |
| mem_wdata | output | DATA_W | Write data (reset command) |
| mem_ack | input | 1 | Bus acknowledge; read data valid in the same cycle |
| mem_rdata | input | DATA_W | Read data |
| busy | output | 1 | High from start until done or fail |
| suspended | output | 1 | High while the bus is yielded |
| done | output | 1 | One-cycle success pulse |
| fail | output | 1 | One-cycle failure pulse |

## Verification
The checker assumes that `mem_ack` only arrives while `mem_req` is high. It also assumes that `start` and `resume` are single-cycle pulses, and that `max_polls` and `status_addr` stay fixed while `busy` is high. The bench's flash model raises its acknowledge only against an open request, after a per-case wait of 0 to 3 cycles. It drops the acknowledge after one cycle. The bench changes the limit and the address only between runs, and it drives every pulse for one cycle on the falling edge.

// File: rtl/tbp_pkg.sv
// Shared types and constants for the toggle-bit status poller.
// Assumes commands travel on the low 16 data lanes.
package tbp_pkg;

    // Sequencer control states
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_ISSUE = 2'd1,
        ST_WAIT  = 2'd2,
        ST_SUSP  = 2'd3
    } seq_state_t;

    // Which bus transfer the sequencer is working on
    typedef enum logic [2:0] {
        STEP_PA  = 3'd0,   // first read of a polling pair
        STEP_PB  = 3'd1,   // second read of a polling pair
        STEP_CA  = 3'd2,   // first read of the confirming pair
        STEP_CB  = 3'd3,   // second read of the confirming pair
        STEP_RST = 3'd4    // reset-command write
    } seq_step_t;

    // Command that returns the flash to array-read mode
    localparam logic [15:0] RESET_CMD = 16'h00F0;

endpackage

// File: rtl/tbp_bus_port.sv
// Request/acknowledge bus master for single transfers.
// A one-cycle 'go' opens a transfer. The request and its attributes are held
// until 'mem_ack'. One cycle after the acknowledge, 'fin' pulses and the two
// status bits of the read word are presented.
// Assumes that 'go' only arrives while no transfer is open.
module tbp_bus_port #(
    parameter int ADDR_W  = 20,
    parameter int DATA_W  = 16,
    parameter int TOG_BIT = 6,
    parameter int TMO_BIT = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              go,
    input  logic              go_we,
    input  logic [ADDR_W-1:0] go_addr,
    input  logic [DATA_W-1:0] go_wdata,
    input  logic              mem_ack,
    input  logic [DATA_W-1:0] mem_rdata,
    output logic              mem_req,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_wdata,
    output logic              fin,
    output logic              fin_tog,
    output logic              fin_tmo
);

    // Open, hold and close one transfer; capture only the status bits
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mem_req   <= 1'b0;
            mem_we    <= 1'b0;
            mem_addr  <= '0;
            mem_wdata <= '0;
            fin       <= 1'b0;
            fin_tog   <= 1'b0;
            fin_tmo   <= 1'b0;
        end else begin
            fin <= 1'b0;
            if (mem_req) begin
                if (mem_ack) begin
                    mem_req <= 1'b0;
                    fin     <= 1'b1;
                    fin_tog <= mem_rdata[TOG_BIT];
                    fin_tmo <= mem_rdata[TMO_BIT];
                end
            end else if (go) begin
                mem_req   <= 1'b1;
                mem_we    <= go_we;
                mem_addr  <= go_addr;
                mem_wdata <= go_wdata;
            end
        end
    end

endmodule

// File: rtl/tbp_poll_cnt.sv
// Counts polling pairs that toggled with the timeout flag clear.
// 'last' is high when the pair now being decided is the final allowed pair.
// A limit of 0 behaves like a limit of 1.
module tbp_poll_cnt #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             inc,
    input  logic [CNT_W-1:0] limit,
    output logic             last
);

    localparam int EXT_W = CNT_W + 1;

    logic [CNT_W-1:0] count;
    logic [EXT_W-1:0] next_num;

    // Number of the pair being decided, widened so that it cannot wrap
    always_comb next_num = {1'b0, count} + EXT_W'(1);

    // Last allowed pair once the pair number reaches the limit
    always_comb last = (next_num >= {1'b0, limit});

    // Pair counter: cleared on each fresh start or resume
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            count <= '0;
        end else if (inc) begin
            count <= count + CNT_W'(1);
        end
    end

endmodule

// File: rtl/tbp_seq.sv
// Decision sequencer for toggle-bit polling.
// Walks the polling pair, the confirming pair and the reset write.
// It honours yield requests only before first-pair reads, and it produces
// the busy/suspended levels and the done/fail pulses.
// Assumes that the bus port signals 'fin' exactly once per 'go'.
module tbp_seq
    import tbp_pkg::*;
#(
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              yield_req,
    input  logic              resume,
    input  logic              fin,
    input  logic              fin_tog,
    input  logic              fin_tmo,
    input  logic              last_pair,
    output logic              go,
    output logic              go_we,
    output logic [DATA_W-1:0] go_wdata,
    output logic              cnt_clr,
    output logic              cnt_inc,
    output logic              busy,
    output logic              suspended,
    output logic              done,
    output logic              fail
);

    seq_state_t state;
    seq_step_t  step;
    logic       tog_prev;
    logic       first_pair;
    logic       may_yield;
    logic       toggled;

    // The first pair can be abandoned; the confirming pair and the write cannot
    always_comb first_pair = (step == STEP_PA) || (step == STEP_PB);
    always_comb may_yield  = first_pair && yield_req;

    // Toggle comparison between the stored read and the read just finished
    always_comb toggled = (fin_tog != tog_prev);

    // Issue a transfer in ISSUE unless the bus is being handed back
    always_comb go    = (state == ST_ISSUE) && !may_yield;
    always_comb go_we = (step == STEP_RST);

    // Only the reset write carries data
    always_comb go_wdata = (step == STEP_RST) ? DATA_W'(RESET_CMD) : '0;

    // Pair count control
    always_comb cnt_clr = ((state == ST_IDLE) && start) || ((state == ST_SUSP) && resume);
    always_comb cnt_inc = (state == ST_WAIT) && fin && (step == STEP_PB)
                          && toggled && !fin_tmo && !last_pair;

    // Status levels follow the control state
    always_comb busy      = (state != ST_IDLE);
    always_comb suspended = (state == ST_SUSP);

    // Main control: state, step, stored toggle value and result pulses
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= ST_IDLE;
            step     <= STEP_PA;
            tog_prev <= 1'b0;
            done     <= 1'b0;
            fail     <= 1'b0;
        end else begin
            done <= 1'b0;
            fail <= 1'b0;
            case (state)
                ST_IDLE: begin
                    if (start) begin
                        state <= ST_ISSUE;
                        step  <= STEP_PA;
                    end
                end
                ST_ISSUE: begin
                    state <= may_yield ? ST_SUSP : ST_WAIT;
                end
                ST_WAIT: begin
                    if (fin) begin
                        state <= ST_ISSUE;
                        case (step)
                            STEP_PA: begin
                                tog_prev <= fin_tog;
                                step     <= STEP_PB;
                            end
                            STEP_PB: begin
                                if (!toggled) begin
                                    state <= ST_IDLE;
                                    done  <= 1'b1;
                                end else if (fin_tmo) begin
                                    step <= STEP_CA;
                                end else if (last_pair) begin
                                    step <= STEP_RST;
                                end else begin
                                    step <= STEP_PA;
                                end
                            end
                            STEP_CA: begin
                                tog_prev <= fin_tog;
                                step     <= STEP_CB;
                            end
                            STEP_CB: begin
                                if (!toggled) begin
                                    state <= ST_IDLE;
                                    done  <= 1'b1;
                                end else begin
                                    step <= STEP_RST;
                                end
                            end
                            default: begin
                                state <= ST_IDLE;
                                fail  <= 1'b1;
                            end
                        endcase
                    end
                end
                default: begin
                    if (resume) begin
                        state <= ST_ISSUE;
                        step  <= STEP_PA;
                    end
                end
            endcase
        end
    end

endmodule

// File: rtl/tbit_poller.sv
// Top of the toggle-bit status poller.
// Joins the decision sequencer, the pair-limit counter and the bus master.
// Assumes that 'status_addr' and 'max_polls' stay fixed while busy.
module tbit_poller #(
    parameter int ADDR_W  = 20,
    parameter int DATA_W  = 16,
    parameter int CNT_W   = 8,
    parameter int TOG_BIT = 6,
    parameter int TMO_BIT = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              yield_req,
    input  logic              resume,
    input  logic [ADDR_W-1:0] status_addr,
    input  logic [CNT_W-1:0]  max_polls,
    output logic              mem_req,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_wdata,
    input  logic              mem_ack,
    input  logic [DATA_W-1:0] mem_rdata,
    output logic              busy,
    output logic              suspended,
    output logic              done,
    output logic              fail
);

    logic              go;
    logic              go_we;
    logic [DATA_W-1:0] go_wdata;
    logic              fin;
    logic              fin_tog;
    logic              fin_tmo;
    logic              cnt_clr;
    logic              cnt_inc;
    logic              last_pair;

    tbp_seq #(.DATA_W(DATA_W)) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (start),
        .yield_req (yield_req),
        .resume    (resume),
        .fin       (fin),
        .fin_tog   (fin_tog),
        .fin_tmo   (fin_tmo),
        .last_pair (last_pair),
        .go        (go),
        .go_we     (go_we),
        .go_wdata  (go_wdata),
        .cnt_clr   (cnt_clr),
        .cnt_inc   (cnt_inc),
        .busy      (busy),
        .suspended (suspended),
        .done      (done),
        .fail      (fail)
    );

    tbp_poll_cnt #(.CNT_W(CNT_W)) u_cnt (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (cnt_clr),
        .inc   (cnt_inc),
        .limit (max_polls),
        .last  (last_pair)
    );

    tbp_bus_port #(
        .ADDR_W  (ADDR_W),
        .DATA_W  (DATA_W),
        .TOG_BIT (TOG_BIT),
        .TMO_BIT (TMO_BIT)
    ) u_bus (
        .clk       (clk),
        .rst_n     (rst_n),
        .go        (go),
        .go_we     (go_we),
        .go_addr   (status_addr),
        .go_wdata  (go_wdata),
        .mem_ack   (mem_ack),
        .mem_rdata (mem_rdata),
        .mem_req   (mem_req),
        .mem_we    (mem_we),
        .mem_addr  (mem_addr),
        .mem_wdata (mem_wdata),
        .fin       (fin),
        .fin_tog   (fin_tog),
        .fin_tmo   (fin_tmo)
    );

endmodule

// File: rtl/tbp_chk.sv
// Property checker for tbit_poller, attached with bind.
// Assumes that the bus acknowledges only open requests.
module tbp_chk #(
    parameter int ADDR_W = 20,
    parameter int DATA_W = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              start,
    input logic              mem_req,
    input logic              mem_we,
    input logic [ADDR_W-1:0] mem_addr,
    input logic [DATA_W-1:0] mem_wdata,
    input logic              mem_ack,
    input logic              busy,
    input logic              suspended,
    input logic              done,
    input logic              fail
);

    // R7
    req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata)));

    // R7
    one_xfer_per_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && mem_ack) |=> !mem_req);

    // R5
    reset_word_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && mem_we) |-> (mem_wdata == DATA_W'(16'h00F0)));

    // R2
    done_ends_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done || fail) |-> (!busy && $past(busy)));

    // R2
    busy_from_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(start));

    // R8
    yield_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        suspended |-> (!mem_req && busy));

    // R10
    no_both_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(done && fail));

    // R10
    single_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done || fail) |=> !(done || fail));

endmodule

bind tbit_poller tbp_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .mem_req   (mem_req),
    .mem_we    (mem_we),
    .mem_addr  (mem_addr),
    .mem_wdata (mem_wdata),
    .mem_ack   (mem_ack),
    .busy      (busy),
    .suspended (suspended),
    .done      (done),
    .fail      (fail)
);

// File: tb/tbit_poller_test.sv
// Self-checking bench for tbit_poller with a behavioural toggling flash model.
module tbit_poller_test;

    localparam int ADDR_W = 20;
    localparam int DATA_W = 16;
    localparam int CNT_W  = 8;
    localparam logic [ADDR_W-1:0] STAT_A = 20'h3A5C4;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              start = 1'b0;
    logic              yield_req = 1'b0;
    logic              resume = 1'b0;
    logic [ADDR_W-1:0] status_addr = STAT_A;
    logic [CNT_W-1:0]  max_polls = 8'd8;
    logic              mem_req;
    logic              mem_we;
    logic [ADDR_W-1:0] mem_addr;
    logic [DATA_W-1:0] mem_wdata;
    logic              mem_ack = 1'b0;
    logic [DATA_W-1:0] mem_rdata = '0;
    logic              busy;
    logic              suspended;
    logic              done;
    logic              fail;

    int errors = 0;
    int checks = 0;
    int cycles = 0;

    always #5 clk = ~clk;

    tbit_poller #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .CNT_W(CNT_W)) uut (
        .clk(clk), .rst_n(rst_n), .start(start), .yield_req(yield_req),
        .resume(resume), .status_addr(status_addr), .max_polls(max_polls),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_ack(mem_ack), .mem_rdata(mem_rdata),
        .busy(busy), .suspended(suspended), .done(done), .fail(fail)
    );

    // Flash model: bit 6 toggles on each read until read index m_stop,
    // then holds; bit 5 is set from read index m_dq5 on.
    int          m_stop = 0;
    int          m_dq5 = 99;
    int          m_lat = 0;
    logic        m_clr = 1'b0;
    int          rd_cnt = 0;
    int          wr_cnt = 0;
    int          bad_addr = 0;
    int          wait_cnt = 0;
    logic [15:0] last_wd = '0;

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (m_clr) begin
            rd_cnt   <= 0;
            wr_cnt   <= 0;
            bad_addr <= 0;
            wait_cnt <= 0;
            mem_ack  <= 1'b0;
        end else if (mem_ack) begin
            mem_ack  <= 1'b0;
            wait_cnt <= 0;
            if (mem_addr != status_addr) bad_addr <= bad_addr + 1;
            if (mem_we) begin
                wr_cnt  <= wr_cnt + 1;
                last_wd <= mem_wdata;
            end else begin
                rd_cnt <= rd_cnt + 1;
            end
        end else if (mem_req) begin
            if (wait_cnt >= m_lat) begin
                mem_ack   <= 1'b1;
                mem_rdata <= 16'h0000
                    | (16'((rd_cnt < m_stop) ? (rd_cnt % 2) : (m_stop % 2)) << 6)
                    | (16'(rd_cnt >= m_dq5) << 5);
            end else begin
                wait_cnt <= wait_cnt + 1;
            end
        end
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic model_clear();
        @(negedge clk);
        m_clr = 1'b1;
        @(negedge clk);
        m_clr = 1'b0;
    endtask

    task automatic pulse_start();
        @(negedge clk);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
    endtask

    // Waits for done or fail; res = 1 pass, 2 fail, 0 timeout
    task automatic wait_result(output int res);
        res = 0;
        for (int i = 0; i < 400; i++) begin
            if (done || fail) begin
                res = done ? 1 : 2;
                break;
            end
            @(negedge clk);
        end
    endtask

    typedef struct packed {
        logic [7:0] stop;
        logic [7:0] dq5;
        logic [7:0] lim;
        logic [1:0] lat;
        logic       exp_fail;
        logic [7:0] reads;
        logic [3:0] req;
    } vec_t;

    localparam vec_t VECS [0:9] = '{
        '{8'd0,   8'd99, 8'd8, 2'd0, 1'b0, 8'd2, 4'd2}, // R2 stable at once
        '{8'd3,   8'd99, 8'd8, 2'd1, 1'b0, 8'd6, 4'd3}, // R3 two more pairs
        '{8'd1,   8'd1,  8'd8, 2'd2, 1'b0, 8'd4, 4'd4}, // R4 confirm stable
        '{8'd10,  8'd1,  8'd8, 2'd0, 1'b1, 8'd4, 4'd5}, // R5 confirm toggles
        '{8'd100, 8'd99, 8'd3, 2'd3, 1'b1, 8'd6, 4'd6}, // R6 limit 3
        '{8'd2,   8'd2,  8'd8, 2'd1, 1'b0, 8'd4, 4'd3}, // R3 stops in pair 2
        '{8'd3,   8'd3,  8'd8, 2'd0, 1'b0, 8'd6, 4'd4}, // R4 flag in pair 2
        '{8'd5,   8'd3,  8'd8, 2'd2, 1'b1, 8'd6, 4'd5}, // R5 after one pair
        '{8'd100, 8'd99, 8'd0, 2'd0, 1'b1, 8'd2, 4'd6}, // R6 limit 0
        '{8'd100, 8'd99, 8'd1, 2'd1, 1'b1, 8'd2, 4'd6}  // R6 limit 1
    };

    initial begin
        int res;
        int rd_snap;
        repeat (3) @(negedge clk);
        // R1: reset state
        check(!busy && !suspended && !done && !fail && !mem_req, "R1 reset", busy, 0);
        rst_n = 1'b1;
        @(negedge clk);

        for (int v = 0; v < 10; v++) begin
            m_stop = int'(VECS[v].stop);
            m_dq5  = int'(VECS[v].dq5);
            m_lat  = int'(VECS[v].lat);
            max_polls = VECS[v].lim;
            model_clear();
            pulse_start();
            check(busy, $sformatf("R2 busy vec%0d", v), busy, 1);
            wait_result(res);
            check(res == (VECS[v].exp_fail ? 2 : 1), $sformatf("R%0d result vec%0d", VECS[v].req, v),
                  res, VECS[v].exp_fail ? 2 : 1);
            check(!busy, $sformatf("R2 busy low at result vec%0d", v), busy, 0);
            check(rd_cnt == int'(VECS[v].reads), $sformatf("R%0d reads vec%0d", VECS[v].req, v),
                  rd_cnt, VECS[v].reads);
            check(wr_cnt == (VECS[v].exp_fail ? 1 : 0), $sformatf("R5 writes vec%0d", v),
                  wr_cnt, VECS[v].exp_fail ? 1 : 0);
            if (VECS[v].exp_fail)
                check(last_wd == 16'h00F0, $sformatf("R5 reset word vec%0d", v), last_wd, 16'h00F0);
            check(bad_addr == 0, $sformatf("R7 address vec%0d", v), bad_addr, 0);
            @(negedge clk);
            check(!done && !fail, $sformatf("R10 single pulse vec%0d", v), done || fail, 0);
        end

        // R8: yield before the first read
        m_stop = 100; m_dq5 = 99; m_lat = 1; max_polls = 8'd200;
        model_clear();
        yield_req = 1'b1;
        pulse_start();
        repeat (5) @(negedge clk);
        check(suspended && busy && !mem_req, "R8 yield at first read", suspended, 1);
        check(rd_cnt == 0, "R8 no read while yielded", rd_cnt, 0);
        // R9: start ignored while busy
        pulse_start();
        repeat (3) @(negedge clk);
        check(suspended && rd_cnt == 0, "R9 start ignored", rd_cnt, 0);
        // R9: resume restarts at the first read
        m_stop = 0;
        model_clear();
        yield_req = 1'b0;
        @(negedge clk); resume = 1'b1; @(negedge clk); resume = 1'b0;
        check(!suspended, "R9 suspended clears", suspended, 0);
        wait_result(res);
        check(res == 1 && rd_cnt == 2, "R9 restart pair", rd_cnt, 2);

        // R8: yield in the middle of polling
        m_stop = 100;
        model_clear();
        pulse_start();
        for (int i = 0; i < 200 && rd_cnt < 3; i++) @(negedge clk);
        yield_req = 1'b1;
        for (int i = 0; i < 50 && !suspended; i++) @(negedge clk);
        check(suspended, "R8 mid-poll yield", suspended, 1);
        rd_snap = rd_cnt;
        repeat (6) @(negedge clk);
        check(rd_cnt == rd_snap && !mem_req, "R8 bus quiet", rd_cnt, rd_snap);
        yield_req = 1'b0;
        m_stop = 0;
        model_clear();
        @(negedge clk); resume = 1'b1; @(negedge clk); resume = 1'b0;
        wait_result(res);
        check(res == 1 && rd_cnt == 2, "R9 resume after mid-poll yield", rd_cnt, 2);

        // R1: reset in the middle of an operation
        m_stop = 100; max_polls = 8'd200;
        model_clear();
        pulse_start();
        repeat (6) @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        check(!busy && !suspended && !mem_req && !done && !fail, "R1 reset mid-run", busy, 0);
        rst_n = 1'b1;
        @(negedge clk);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    // Watchdog
    initial begin
        wait (cycles > 100000);
        errors++;
        checks++;
        $display("FAIL watchdog: actual=%0d expected=%0d", cycles, 100000);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule